// File: doc/BRIEF.md
# Cache RAM Debug Access Port

This block is a slave front end that lets a debug master read and write the eight data banks of a cache directly, using AXI-style address, data and response channels. Every transaction header is screened against a fixed set of access rules before any RAM is touched. A header or beat that breaks a rule leaves the RAMs unchanged and is answered with a slave error. A legal one is steered to a bank and a row, one beat at a time.

The banks are 64 bits wide. A 64-bit beat writes one row. A 32-bit write burst is assembled in pairs: the low word is held in a register and the row is written when the high word arrives. Only one transaction runs at a time, and a write that arrives together with a read is taken first. The bank storage is a simple behavioural array inside the block.

Top module: `cache_ram_dbg_port`

## Requirements
- R1: Transfer size codes 2 (32-bit) and 3 (64-bit) are legal. Any other size on a read or a write gives a slave error (response code 2'b10, OKAY being 2'b00), and a rejected write changes no RAM row.
- R2: A read whose start address has bits [1:0] other than 2'b00 is rejected with a slave error. A word-aligned 32-bit read is accepted, and each of its beats returns the whole 64-bit row.
- R3: A write whose start address has bits [2:0] other than 3'b000 is rejected with a slave error and writes nothing.
- R4: A 64-bit write beat needs strobe 8'hFF. A 32-bit write beat needs strobe 8'h0F when address bit 2 of the beat is 0 and 8'hF0 when it is 1. A beat with any other strobe, and every later beat of the same burst, writes nothing, and the burst ends with a slave error.
- R5: A 32-bit write with burst code 0 (FIXED), or with an even length field (an odd number of beats), is rejected with a slave error and writes nothing.
- R6: Burst codes 0 (FIXED) and 1 (INCR) are accepted. Codes 2 and 3 are rejected with a slave error on reads and writes.
- R7: Address bits [18:15] must be one-hot. Code 0001 selects banks 0/1, 0010 banks 2/3, 0100 banks 4/5 and 1000 banks 6/7, with address bit 3 choosing the odd bank of each pair. The row is address bits [ROW_BITS+3:4]. A beat outside a one-hot region is answered with a slave error and touches no RAM.
- R8: In an INCR burst the beat address grows by 4 or 8 bytes (32-bit or 64-bit size) on every beat, and the bank is decoded again for each beat. In a FIXED burst every beat uses the start address.
- R9: In a 32-bit write burst each pair of beats produces one row write. The row's low word is bits [31:0] of the first beat and its high word is bits [63:32] of the second.
- R10: Every write transaction, legal or not, returns exactly one write response, and only after all length+1 data beats have been accepted. The response stays steady until it is accepted.
- R11: A legal read returns length+1 beats of row data with OKAY. A rejected read still returns length+1 beats, each with zero data and a slave error, and the last-beat flag is set on the final beat only.
- R12: One transaction is active at a time: while a write or a read is in progress both address-channel ready outputs are low. In idle, when both address channels are valid, the write is taken and the read-address ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| aw_addr | input | ADDR_W | Write start address |
| aw_len | input | LEN_W | Write beat count minus one |
| aw_size | input | 3 | Write transfer size code |
| aw_burst | input | 2 | Write burst type |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data ready |
| w_data | input | 64 | Write data |
| w_strb | input | 8 | Write byte strobes |
| w_last | input | 1 | Final write beat marker (not used for sequencing) |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_resp | output | 2 | Write response code |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address ready |
| ar_addr | input | ADDR_W | Read start address |
| ar_len | input | LEN_W | Read beat count minus one |
| ar_size | input | 3 | Read transfer size code |
| ar_burst | input | 2 | Read burst type |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_data | output | 64 | Read data |
| r_resp | output | 2 | Read response code |
| r_last | output | 1 | Final read beat marker |

## Verification
The assertions watch, on every cycle, the properties that hold regardless of data: a header with an illegal size at once marks the transaction as failed, a failed write stays failed until its response, a waiting write response does not change, a transaction ends with its last read beat, and accepting a write closes the read-address channel. The bench's scenarios show what only data can reveal. These are the bank and row each beat lands in, the pairing of 32-bit words into rows, the advance of INCR addresses against the fixed address of FIXED bursts, and the survival of earlier rows after a rejected or part-rejected write. Those are read back and compared against a shadow model of the banks.

// File: rtl/cache_ram_dbg_port.sv
module cache_ram_dbg_port #(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 8,
  parameter int ROW_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aw_valid,
  output logic              aw_ready,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [LEN_W-1:0]  aw_len,
  input  logic [2:0]        aw_size,
  input  logic [1:0]        aw_burst,
  input  logic              w_valid,
  output logic              w_ready,
  input  logic [63:0]       w_data,
  input  logic [7:0]        w_strb,
  input  logic              w_last,
  output logic              b_valid,
  input  logic              b_ready,
  output logic [1:0]        b_resp,
  input  logic              ar_valid,
  output logic              ar_ready,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [LEN_W-1:0]  ar_len,
  input  logic [2:0]        ar_size,
  input  logic [1:0]        ar_burst,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [63:0]       r_data,
  output logic [1:0]        r_resp,
  output logic              r_last
);

  localparam int BANKS = 8;
  localparam int ROWS  = 1 << ROW_BITS;
  localparam int IDX_W = 3 + ROW_BITS;
  localparam logic [1:0] RESP_OK  = 2'b00;
  localparam logic [1:0] RESP_SLV = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_WR, S_BRESP, S_RD} st_t;

  st_t               st;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  cnt_q;
  logic              wide_q, fixed_q, err_q;
  logic [31:0]       lo_q;
  logic [63:0]       mem [BANKS*ROWS];

  function automatic logic hdr_bad(input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] len,
                                   input logic [2:0] sz, input logic [1:0] bu, input logic wr);
    hdr_bad = (sz != 3'd2 && sz != 3'd3) || bu[1]
            || (wr ? (a[2:0] != 3'b000) : (a[1:0] != 2'b00))
            || (wr && sz == 3'd2 && (bu == 2'b00 || !len[0]));
  endfunction

  wire [3:0]       region = addr_q[18:15];
  wire             dec_ok = $onehot(region);
  wire [IDX_W-1:0] idx    = {region[3] | region[2], region[3] | region[1], addr_q[3], addr_q[ROW_BITS+3:4]};
  wire [63:0]      rd_row = mem[idx];

  wire strb_ok = wide_q ? (&w_strb) : (w_strb == (addr_q[2] ? 8'hF0 : 8'h0F));
  wire w_beat  = w_valid && w_ready;
  wire r_beat  = r_valid && r_ready;
  wire wr_err  = err_q | ~dec_ok | ~strb_ok;
  wire rd_err  = err_q | ~dec_ok;
  wire mem_we  = w_beat && !wr_err && (wide_q || addr_q[2]);
  wire [ADDR_W-1:0] addr_nx = fixed_q ? addr_q : addr_q + ADDR_W'(wide_q ? 8 : 4);
  wire unused_bits = ^{w_last, addr_q};

  assign aw_ready = (st == S_IDLE);
  assign ar_ready = (st == S_IDLE) && !aw_valid;
  assign w_ready  = (st == S_WR);
  assign b_valid  = (st == S_BRESP);
  assign b_resp   = err_q ? RESP_SLV : RESP_OK;
  assign r_valid  = (st == S_RD);
  assign r_resp   = rd_err ? RESP_SLV : RESP_OK;
  assign r_data   = rd_err ? 64'd0 : rd_row;
  assign r_last   = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      wide_q  <= 1'b0;
      fixed_q <= 1'b0;
      err_q   <= 1'b0;
      lo_q    <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (aw_valid) begin
            st      <= S_WR;
            addr_q  <= aw_addr;
            cnt_q   <= aw_len;
            wide_q  <= (aw_size == 3'd3);
            fixed_q <= (aw_burst == 2'b00);
            err_q   <= hdr_bad(aw_addr, aw_len, aw_size, aw_burst, 1'b1);
          end else if (ar_valid) begin
            st      <= S_RD;
            addr_q  <= ar_addr;
            cnt_q   <= ar_len;
            wide_q  <= (ar_size == 3'd3);
            fixed_q <= (ar_burst == 2'b00);
            err_q   <= hdr_bad(ar_addr, ar_len, ar_size, ar_burst, 1'b0);
          end
        end
        S_WR: begin
          if (w_valid) begin
            err_q  <= wr_err;
            addr_q <= addr_nx;
            if (!wide_q && !addr_q[2]) lo_q <= w_data[31:0];
            if (cnt_q == '0) st <= S_BRESP;
            else cnt_q <= cnt_q - 1'b1;
          end
        end
        S_BRESP: if (b_ready) st <= S_IDLE;
        S_RD: begin
          if (r_ready) begin
            err_q  <= rd_err;
            addr_q <= addr_nx;
            if (cnt_q == '0) st <= S_IDLE;
            else cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[idx] <= wide_q ? w_data : {w_data[63:32], lo_q};
  end

  p_bad_size_r1: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid && aw_ready && (aw_size[2:1] == 2'b00) |=> err_q);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR) && err_q |=> err_q);

  p_bresp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid && !b_ready |=> b_valid && $stable(b_resp));

  p_last_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
    r_beat && r_last |=> !r_valid);

  p_one_active_r12: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid && aw_ready |=> !ar_ready && !aw_ready);

endmodule

// File: tb/cache_ram_dbg_port_bench.sv
`timescale 1ns/1ps
module cache_ram_dbg_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        aw_valid = 0, aw_ready;
  logic [31:0] aw_addr = 0;
  logic [7:0]  aw_len = 0;
  logic [2:0]  aw_size = 0;
  logic [1:0]  aw_burst = 0;
  logic        w_valid = 0, w_ready, w_last = 0;
  logic [63:0] w_data = 0;
  logic [7:0]  w_strb = 0;
  logic        b_valid, b_ready = 1;
  logic [1:0]  b_resp;
  logic        ar_valid = 0, ar_ready;
  logic [31:0] ar_addr = 0;
  logic [7:0]  ar_len = 0;
  logic [2:0]  ar_size = 0;
  logic [1:0]  ar_burst = 0;
  logic        r_valid, r_ready = 1, r_last;
  logic [63:0] r_data;
  logic [1:0]  r_resp;

  cache_ram_dbg_port u_cache_ram_dbg_port (
    .clk(clk), .rst_n(rst_n),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_len(aw_len),
    .aw_size(aw_size), .aw_burst(aw_burst),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb), .w_last(w_last),
    .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_len(ar_len),
    .ar_size(ar_size), .ar_burst(ar_burst),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_resp(r_resp), .r_last(r_last)
  );

  int nchk = 0, nfail = 0;
  logic [63:0] model [128];
  logic [63:0] q_data[$];
  logic [1:0]  q_resp[$];
  logic        q_last[$];
  string       q_tag[$];
  logic [1:0]  qb_resp[$];
  string       qb_tag[$];

  function automatic void check(bit ok, string tag, logic [66:0] act, logic [66:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  function automatic int row_idx(logic [31:0] a, output bit ok);
    int enc;
    ok = 1;
    case (a[18:15])
      4'b0001: enc = 0;
      4'b0010: enc = 1;
      4'b0100: enc = 2;
      4'b1000: enc = 3;
      default: begin enc = 0; ok = 0; end
    endcase
    return (enc * 2 + int'(a[3])) * 16 + int'(a[7:4]);
  endfunction

  function automatic logic [63:0] beat_data(logic [31:0] seed, int i);
    return {seed ^ 32'hC0DE_0000 ^ i, seed + i * 7 + 32'h100};
  endfunction

  task automatic wr(input logic [31:0] a, input logic [7:0] len, input logic [2:0] sz,
                    input logic [1:0] bu, input int bad, input logic [31:0] seed, input string tag);
    bit err, ok;
    logic [31:0] ad, lo;
    logic [63:0] d;
    int ix;
    err = !(sz == 3'd2 || sz == 3'd3) || bu[1] || (a[2:0] != 3'b000)
        || (sz == 3'd2 && (bu == 2'b00 || !len[0]));
    ad = a; lo = 0;
    for (int i = 0; i <= int'(len); i++) begin
      d = beat_data(seed, i);
      ix = row_idx(ad, ok);
      err = err || !ok || (i == bad);
      if (!err && (sz == 3'd3 || ad[2])) model[ix] = (sz == 3'd3) ? d : {d[63:32], lo};
      if (sz == 3'd2 && !ad[2]) lo = d[31:0];
      if (bu != 2'b00) ad = ad + ((sz == 3'd3) ? 8 : 4);
    end
    qb_resp.push_back(err ? 2'b10 : 2'b00);
    qb_tag.push_back(tag);
    @(negedge clk);
    aw_addr = a; aw_len = len; aw_size = sz; aw_burst = bu; aw_valid = 1;
    while (!aw_ready) @(negedge clk);
    @(negedge clk);
    aw_valid = 0;
    check(!ar_ready && !aw_ready, "R12 ready outputs low during write", {ar_ready, aw_ready}, 0);
    ad = a;
    for (int i = 0; i <= int'(len); i++) begin
      w_data = beat_data(seed, i);
      w_strb = (sz == 3'd3) ? 8'hFF : (ad[2] ? 8'hF0 : 8'h0F);
      if (i == bad) w_strb = ~w_strb;
      w_last = (i == int'(len));
      w_valid = 1;
      @(negedge clk);
      if (bu != 2'b00) ad = ad + ((sz == 3'd3) ? 8 : 4);
    end
    w_valid = 0;
    w_last = 0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [7:0] len, input logic [2:0] sz,
                    input logic [1:0] bu, input string tag);
    bit err, ok, e;
    logic [31:0] ad;
    int ix;
    err = !(sz == 3'd2 || sz == 3'd3) || bu[1] || (a[1:0] != 2'b00);
    ad = a;
    for (int i = 0; i <= int'(len); i++) begin
      ix = row_idx(ad, ok);
      e = err || !ok;
      q_data.push_back(e ? 64'd0 : model[ix]);
      q_resp.push_back(e ? 2'b10 : 2'b00);
      q_last.push_back(i == int'(len));
      q_tag.push_back(tag);
      err = e;
      if (bu != 2'b00) ad = ad + ((sz == 3'd3) ? 8 : 4);
    end
    @(negedge clk);
    ar_addr = a; ar_len = len; ar_size = sz; ar_burst = bu; ar_valid = 1;
    while (!ar_ready) @(negedge clk);
    @(negedge clk);
    ar_valid = 0;
  endtask

  logic [63:0] m_data;
  logic [1:0]  m_resp;
  logic        m_last;
  string       m_tag;

  always @(negedge clk) begin
    if (rst_n) begin
      if (b_valid) begin
        if (qb_resp.size() == 0) check(0, "R10 unexpected write response", {65'd0, b_resp}, 0);
        else begin
          m_resp = qb_resp.pop_front();
          m_tag = qb_tag.pop_front();
          check(b_resp === m_resp, m_tag, {65'd0, b_resp}, {65'd0, m_resp});
        end
      end
      if (r_valid) begin
        if (q_data.size() == 0) check(0, "R11 unexpected read beat", {r_data, r_resp, r_last}, 0);
        else begin
          m_data = q_data.pop_front();
          m_resp = q_resp.pop_front();
          m_last = q_last.pop_front();
          m_tag = q_tag.pop_front();
          check({r_data, r_resp, r_last} === {m_data, m_resp, m_last}, m_tag,
                {r_data, r_resp, r_last}, {m_data, m_resp, m_last});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL R12 watchdog expired actual=hung expected=idle");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 64'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(aw_ready && !b_valid && !r_valid, "R12 reset state idle",
          {aw_ready, b_valid, r_valid}, 3'b100);

    wr(32'h0000_8000, 1, 3, 1, -1, 32'h11, "R7 R8 64-bit incr write");
    rd(32'h0000_8000, 1, 3, 1, "R7 R8 64-bit incr read");
    wr(32'h0001_0010, 3, 2, 1, -1, 32'h22, "R9 32-bit pair write");
    rd(32'h0001_0010, 3, 2, 1, "R9 32-bit pair read back");
    wr(32'h0002_0028, 2, 3, 0, -1, 32'h33, "R8 fixed 64-bit write");
    rd(32'h0002_0028, 0, 3, 1, "R8 fixed read back");
    wr(32'h0004_0000, 3, 3, 1, -1, 32'h44, "R7 region 1000 fill");
    wr(32'h0004_0000, 3, 3, 1, 2, 32'h55, "R4 strobe error mid burst");
    rd(32'h0004_0000, 3, 3, 1, "R4 partial write read back");

    wr(32'h0000_8000, 1, 1, 1, -1, 32'h66, "R1 16-bit write rejected");
    wr(32'h0000_8000, 1, 0, 1, -1, 32'h67, "R1 8-bit write rejected");
    rd(32'h0000_8000, 1, 3, 1, "R1 RAM unchanged");
    rd(32'h0000_8000, 1, 1, 1, "R1 16-bit read rejected");

    wr(32'h0000_8004, 0, 3, 1, -1, 32'h77, "R3 misaligned 64-bit write");
    wr(32'h0000_8004, 1, 2, 1, -1, 32'h78, "R3 misaligned 32-bit write");
    rd(32'h0000_8000, 1, 3, 1, "R3 RAM unchanged");

    wr(32'h0000_8000, 1, 3, 1, 0, 32'h88, "R4 bad 64-bit strobe");
    wr(32'h0001_0010, 1, 2, 1, 0, 32'h99, "R4 bad 32-bit strobe");
    rd(32'h0000_8000, 1, 3, 1, "R4 RAM unchanged 64-bit");
    rd(32'h0001_0010, 3, 2, 1, "R4 RAM unchanged 32-bit");

    wr(32'h0001_0010, 1, 2, 0, -1, 32'hAA, "R5 32-bit fixed rejected");
    wr(32'h0001_0010, 2, 2, 1, -1, 32'hAB, "R5 32-bit odd beat count rejected");
    rd(32'h0001_0010, 1, 3, 1, "R5 RAM unchanged");

    wr(32'h0000_8000, 1, 3, 2, -1, 32'hBB, "R6 wrap write rejected");
    wr(32'h0000_8000, 0, 3, 3, -1, 32'hBC, "R6 reserved burst rejected");
    rd(32'h0000_8000, 1, 3, 2, "R6 wrap read rejected");
    rd(32'h0000_8000, 1, 3, 1, "R6 RAM unchanged");

    wr(32'h0001_8000, 1, 3, 1, -1, 32'hCC, "R7 non-one-hot region write");
    rd(32'h0001_8000, 2, 3, 1, "R11 rejected read beats");

    rd(32'h0000_8002, 0, 2, 1, "R2 unaligned read rejected");
    rd(32'h0000_8004, 0, 2, 1, "R2 word aligned read");

    while (q_data.size() != 0 || qb_resp.size() != 0 || !aw_ready) @(negedge clk);
    aw_addr = 32'h0000_8000; aw_len = 0; aw_size = 3; aw_burst = 1;
    ar_addr = 32'h0000_8000; ar_len = 0; ar_size = 3; ar_burst = 1;
    aw_valid = 1; ar_valid = 1;
    #1;
    check(aw_ready && !ar_ready, "R12 write wins over read in idle", {aw_ready, ar_ready}, 2'b10);
    aw_valid = 0; ar_valid = 0;

    repeat (4) @(negedge clk);
    check(q_data.size() == 0 && qb_resp.size() == 0, "R10 R11 all responses seen",
          q_data.size() + qb_resp.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule